// File: doc/BRIEF.md
# Conditional Branch and Loop Unit

This unit resolves control flow for the short-branch instruction group and for the count-down loop instruction of a 16-bit processor with an octal opcode map. Each cycle it takes one instruction word, the four condition flags, the program counter (already advanced past the instruction) and the value of the register named by the loop instruction. One clock later it presents whether the branch is taken, the next program counter, a register write for the loop counter, and new condition flags.

Branch offsets are signed 8-bit word counts. The loop instruction only jumps backward, by an unsigned 6-bit word count. The same unit also decodes the flag set and clear group. Any other instruction word passes through with no branch, no register write and no flag change.

Top module: `bcu_top`

## Requirements
- R1: While `rst_ni` is low, every output is zero.
- R2: Outputs reflect the inputs of the previous rising clock edge. Changing the inputs does not move the outputs before the next edge.
- R3: For a branch word the target is `pc_i` plus twice bits 7:0 of the word, read as a signed two's-complement value, modulo 2^16. `next_pc_o` is that target when the branch is taken.
- R4: `flags_i` bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. The octal words 000400 (always), 001000/001400 (Z clear/set), 100000/100400 (N clear/set), 102000/102400 (V clear/set) and 103000/103400 (C clear/set) are taken under the stated condition.
- R5: Signed conditions: 002000 is taken when N xor V is 0 and 002400 when it is 1. 003000 is taken when Z or (N xor V) is 0 and 003400 when it is 1.
- R6: Unsigned conditions: 101000 is taken when C and Z are both 0. 101400 is taken when C or Z is 1.
- R7: When no branch is taken, `next_pc_o` equals `pc_i` and `taken_o` is 0.
- R8: For octal word 077RNN, `reg_wr_o` is 1, `reg_idx_o` is R (bits 8:6) and `reg_wdata_o` is `reg_i` minus 1, modulo 2^16.
- R9: The loop instruction is taken exactly when the decremented value is nonzero. Its target is `pc_i` minus twice NN (bits 5:0, unsigned).
- R10: For octal words 000240 to 000277, bits 3:0 select N, Z, V and C (bit 3 = N). Bit 4 = 1 sets the selected flags and bit 4 = 0 clears them. Unselected flags keep their `flags_i` value.
- R11: `flags_wr_o` is 1 only for a flag-group word with a nonzero mask. Word 000240 changes nothing.
- R12: Branch and loop words leave `flags_o` equal to `flags_i` with `flags_wr_o` 0.
- R13: Any other word gives `taken_o` 0, `reg_wr_o` 0, `flags_wr_o` 0 and `flags_o` equal to `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| insn_i | input | 16 | Instruction word |
| flags_i | input | 4 | Current flags {N,Z,V,C} |
| pc_i | input | 16 | PC after the instruction |
| reg_i | input | 16 | Value of the loop register |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| reg_wr_o | output | 1 | Loop register write enable |
| reg_idx_o | output | 3 | Loop register index |
| reg_wdata_o | output | 16 | Decremented loop register |
| flags_wr_o | output | 1 | Flags changed |
| flags_o | output | 4 | New flags {N,Z,V,C} |

## Verification
A wrong decode class shows up in the cycle after the word is applied. It appears as a branch taken on a non-branch word, as a stray register or flag write, or as altered flags after a branch. A miswired condition term shows up only under particular flag patterns. For that reason every branch opcode is run against all sixteen flag combinations. An adder or sign-extension fault shows as a wrong `next_pc_o` only for offsets near the sign boundary or near address wrap, so those edges are driven on purpose.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    localparam int INSN_W = 16;
    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_LOOP   = 2'd2,
        CLS_FLAGS  = 2'd3
    } insn_class_e;
endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output insn_class_e       cls_o,
    output logic [3:0]        cond_sel_o
);
    logic [3:0] sel;

    always_comb begin
        sel = {insn_i[15], insn_i[10:8]};
        if (insn_i[14:11] == 4'd0 && sel != 4'd0) begin
            cls_o = CLS_BRANCH;
        end else if (insn_i[15:9] == 7'b0111111) begin
            cls_o = CLS_LOOP;
        end else if (insn_i[15:5] == 11'b00000000101) begin
            cls_o = CLS_FLAGS;
        end else begin
            cls_o = CLS_NONE;
        end
        cond_sel_o = sel;
    end
endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
(
    input  logic [3:0]        cond_sel_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              take_o
);
    logic n, z, v, c, base;

    always_comb begin
        n = flags_i[3];
        z = flags_i[2];
        v = flags_i[1];
        c = flags_i[0];
        unique case (cond_sel_i[3:1])
            3'd0:    base = 1'b1;
            3'd1:    base = z;
            3'd2:    base = n ^ v;
            3'd3:    base = z | (n ^ v);
            3'd4:    base = n;
            3'd5:    base = c | z;
            3'd6:    base = v;
            default: base = c;
        endcase
        take_o = cond_sel_i[0] ? base : ~base;
    end
endmodule

// File: rtl/bcu_target.sv
module bcu_target
    import bcu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic [INSN_W-1:0] insn_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              is_loop_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int SEXT_W = ADDR_W - OFFS_W - 1;
    localparam int ZEXT_W = ADDR_W - CNT_W - 1;

    logic [ADDR_W-1:0] fwd_step, back_step, addend;

    always_comb begin
        fwd_step  = {{SEXT_W{insn_i[OFFS_W-1]}}, insn_i[OFFS_W-1:0], 1'b0};
        back_step = {{ZEXT_W{1'b0}}, insn_i[CNT_W-1:0], 1'b0};
        addend    = is_loop_i ? (~back_step + 1'b1) : fwd_step;
        target_o  = pc_i + addend;
    end
endmodule

// File: rtl/bcu_flag_unit.sv
module bcu_flag_unit
    import bcu_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    input  logic              is_flag_op_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              flags_wr_o
);
    logic [FLAG_W-1:0] mask;

    always_comb begin
        mask = insn_i[FLAG_W-1:0];
        if (is_flag_op_i) begin
            flags_o    = insn_i[FLAG_W] ? (flags_i | mask) : (flags_i & ~mask);
            flags_wr_o = (mask != '0);
        end else begin
            flags_o    = flags_i;
            flags_wr_o = 1'b0;
        end
    end
endmodule

// File: rtl/bcu_top.sv
module bcu_top
    import bcu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 8,
    parameter int CNT_W  = 6,
    parameter int RIDX_W = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [INSN_W-1:0]    insn_i,
    input  logic [FLAG_W-1:0]    flags_i,
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic [ADDR_W-1:0]    reg_i,
    output logic                 taken_o,
    output logic [ADDR_W-1:0]    next_pc_o,
    output logic                 reg_wr_o,
    output logic [RIDX_W-1:0]    reg_idx_o,
    output logic [ADDR_W-1:0]    reg_wdata_o,
    output logic                 flags_wr_o,
    output logic [FLAG_W-1:0]    flags_o
);
    localparam int RIDX_LSB = CNT_W;

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] next_pc;
        logic              reg_wr;
        logic [RIDX_W-1:0] reg_idx;
        logic [ADDR_W-1:0] reg_wdata;
        logic              flags_wr;
        logic [FLAG_W-1:0] flags;
    } bcu_out_t;

    bcu_out_t out_d, out_q;

    insn_class_e       cls_d;
    logic [3:0]        cond_sel;
    logic              cond_take;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] dec_val;
    logic [FLAG_W-1:0] fu_flags;
    logic              fu_wr;

    bcu_decode u_decode (
        .insn_i     (insn_i),
        .cls_o      (cls_d),
        .cond_sel_o (cond_sel)
    );

    bcu_cond_eval u_cond (
        .cond_sel_i (cond_sel),
        .flags_i    (flags_i),
        .take_o     (cond_take)
    );

    bcu_target #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W),
        .CNT_W  (CNT_W)
    ) u_target (
        .insn_i    (insn_i),
        .pc_i      (pc_i),
        .is_loop_i (cls_d == CLS_LOOP),
        .target_o  (target)
    );

    bcu_flag_unit u_flags (
        .insn_i       (insn_i),
        .is_flag_op_i (cls_d == CLS_FLAGS),
        .flags_i      (flags_i),
        .flags_o      (fu_flags),
        .flags_wr_o   (fu_wr)
    );

    always_comb begin
        dec_val         = reg_i - 1'b1;
        out_d           = '0;
        out_d.next_pc   = pc_i;
        out_d.flags     = fu_flags;
        out_d.flags_wr  = fu_wr;
        unique case (cls_d)
            CLS_BRANCH: begin
                out_d.taken = cond_take;
            end
            CLS_LOOP: begin
                out_d.taken     = (dec_val != '0);
                out_d.reg_wr    = 1'b1;
                out_d.reg_idx   = insn_i[RIDX_LSB +: RIDX_W];
                out_d.reg_wdata = dec_val;
            end
            default: begin
                out_d.taken = 1'b0;
            end
        endcase
        if (out_d.taken) begin
            out_d.next_pc = target;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign taken_o     = out_q.taken;
    assign next_pc_o   = out_q.next_pc;
    assign reg_wr_o    = out_q.reg_wr;
    assign reg_idx_o   = out_q.reg_idx;
    assign reg_wdata_o = out_q.reg_wdata;
    assign flags_wr_o  = out_q.flags_wr;
    assign flags_o     = out_q.flags;

    // R12: control-flow words never touch the flags
    assert_flags_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls_d == CLS_BRANCH || cls_d == CLS_LOOP)
        |=> (!flags_wr_o && flags_o == $past(flags_i)));

    // R13: unrelated words stay quiet
    assert_other_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls_d == CLS_NONE)
        |=> (!taken_o && !reg_wr_o && !flags_wr_o && flags_o == $past(flags_i)));

    // R7: the fall-through address is the incoming PC
    assert_fallthrough_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls_d == CLS_NONE || cls_d == CLS_FLAGS) |=> (next_pc_o == $past(pc_i)));

    // R9: the loop branches exactly on a nonzero count
    assert_loop_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_wr_o |-> (taken_o == (reg_wdata_o != '0)));

    // R11: the register and flag writes never occur together
    assert_single_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({reg_wr_o, flags_wr_o}));

    // R8: the decremented value follows the register input
    assert_loop_dec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cls_d == CLS_LOOP) |=> (reg_wr_o && reg_wdata_o == $past(reg_i) - 1'b1));
endmodule

// File: tb/bcu_top_tb_top.sv
`timescale 1ns/1ps
module bcu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] insn = '0;
    logic [3:0]  flags = '0;
    logic [15:0] pc = '0;
    logic [15:0] rv = '0;
    logic        taken_o, reg_wr_o, flags_wr_o;
    logic [15:0] next_pc_o, reg_wdata_o;
    logic [2:0]  reg_idx_o;
    logic [3:0]  flags_o;

    int n_checks = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic        taken;
        logic [15:0] next_pc;
        logic        reg_wr;
        logic [2:0]  reg_idx;
        logic [15:0] wdata;
        logic        flags_wr;
        logic [3:0]  flags;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    bcu_top dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .insn_i      (insn),
        .flags_i     (flags),
        .pc_i        (pc),
        .reg_i       (rv),
        .taken_o     (taken_o),
        .next_pc_o   (next_pc_o),
        .reg_wr_o    (reg_wr_o),
        .reg_idx_o   (reg_idx_o),
        .reg_wdata_o (reg_wdata_o),
        .flags_wr_o  (flags_wr_o),
        .flags_o     (flags_o)
    );

    function automatic exp_t model(logic [15:0] w, logic [3:0] f, logic [15:0] p,
                                   logic [15:0] r, string tag);
        exp_t e;
        logic n, z, v, c, br, cnd;
        logic [15:0] off;
        n = f[3]; z = f[2]; v = f[1]; c = f[0];
        e.taken = 0; e.next_pc = p; e.reg_wr = 0; e.reg_idx = 0; e.wdata = 0;
        e.flags_wr = 0; e.flags = f; e.tag = tag;
        off = {{7{w[7]}}, w[7:0], 1'b0};
        br = 1'b1; cnd = 1'b0;
        case (w & 16'o177400)
            16'o000400: cnd = 1'b1;
            16'o001000: cnd = !z;
            16'o001400: cnd = z;
            16'o002000: cnd = !(n ^ v);
            16'o002400: cnd = n ^ v;
            16'o003000: cnd = !(z | (n ^ v));
            16'o003400: cnd = z | (n ^ v);
            16'o100000: cnd = !n;
            16'o100400: cnd = n;
            16'o101000: cnd = !(c | z);
            16'o101400: cnd = c | z;
            16'o102000: cnd = !v;
            16'o102400: cnd = v;
            16'o103000: cnd = !c;
            16'o103400: cnd = c;
            default:    br = 1'b0;
        endcase
        if (br) begin
            e.taken = cnd;
            if (cnd) e.next_pc = p + off;
        end else if (w[15:9] == 7'o077) begin
            e.reg_wr = 1; e.reg_idx = w[8:6]; e.wdata = r - 16'd1;
            e.taken = (e.wdata != 0);
            if (e.taken) e.next_pc = p - {9'd0, w[5:0], 1'b0};
        end else if (w >= 16'o000240 && w <= 16'o000277) begin
            e.flags = w[4] ? (f | w[3:0]) : (f & ~w[3:0]);
            e.flags_wr = (w[3:0] != 0);
        end
        return e;
    endfunction

    task automatic drive(logic [15:0] w, logic [3:0] f, logic [15:0] p,
                         logic [15:0] r, string tag);
        @(negedge clk);
        insn = w; flags = f; pc = p; rv = r;
        sb_q.push_back(model(w, f, p, r, tag));
    endtask

    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            bit ok;
            e = sb_q.pop_front();
            ok = (taken_o == e.taken) && (next_pc_o == e.next_pc) &&
                 (reg_wr_o == e.reg_wr) && (flags_wr_o == e.flags_wr) &&
                 (flags_o == e.flags) &&
                 (!e.reg_wr || (reg_wdata_o == e.wdata && reg_idx_o == e.reg_idx));
            n_checks++;
            if (!ok) begin
                n_bad++;
                $display("FAIL %s insn=%o: got tk=%b pc=%h rw=%b ri=%0d wd=%h fw=%b f=%b exp tk=%b pc=%h rw=%b ri=%0d wd=%h fw=%b f=%b",
                    e.tag, $past(insn), taken_o, next_pc_o, reg_wr_o, reg_idx_o, reg_wdata_o,
                    flags_wr_o, flags_o, e.taken, e.next_pc, e.reg_wr, e.reg_idx, e.wdata,
                    e.flags_wr, e.flags);
            end
        end
    end

    task automatic check1(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        insn = 16'o103400; flags = 4'hF; pc = 16'h1234; rv = 16'h5;
        repeat (3) @(negedge clk);
        // R1: everything zero while reset is held
        check1({taken_o, next_pc_o, reg_wr_o, reg_idx_o, reg_wdata_o, flags_wr_o, flags_o} == '0,
               "R1", "reset outputs", {15'd0, taken_o, next_pc_o}, 32'd0);
        insn = 16'o000240; flags = 4'h0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: a new word does not reach the outputs before the edge
        drive(16'o000240, 4'h0, 16'h0100, 16'h0, "R11");
        @(negedge clk);
        insn = 16'o000401; pc = 16'h0200;
        sb_q.push_back(model(16'o000401, 4'h0, 16'h0200, 16'h0, "R2"));
        #1;
        check1(taken_o == 1'b0, "R2", "early output", {31'd0, taken_o}, 32'd0);

        // R3: offsets at sign edges and address wrap
        drive(16'o000400 | 16'h7F, 4'h0, 16'h1000, 16'h0, "R3");
        drive(16'o000400 | 16'h80, 4'h0, 16'h1000, 16'h0, "R3");
        drive(16'o000400 | 16'hFF, 4'h0, 16'h1000, 16'h0, "R3");
        drive(16'o000400 | 16'h00, 4'h0, 16'h1000, 16'h0, "R3");
        drive(16'o000400 | 16'h10, 4'h0, 16'hFFF0, 16'h0, "R3");
        drive(16'o000400 | 16'hF0, 4'h0, 16'h0008, 16'h0, "R3");

        // R4 R5 R6 R7 R12: every branch under every flag pattern
        for (int op = 0; op < 16; op++) begin
            logic [15:0] base;
            string tg;
            base = {op[3], 4'b0000, op[2:0], 8'h00};
            if (base == 16'h0) continue;
            case (base)
                16'o002000, 16'o002400, 16'o003000, 16'o003400: tg = "R5";
                16'o101000, 16'o101400: tg = "R6";
                default: tg = "R4";
            endcase
            for (int fl = 0; fl < 16; fl++) begin
                drive(base | 16'(8'(op * 13 + fl * 7)), fl[3:0], 16'h4000 + 16'(op * 64), 16'h0, tg);
            end
        end
        drive(16'o001005, 4'b0100, 16'h2222, 16'h0, "R7");
        drive(16'o100405, 4'b0111, 16'h3333, 16'h0, "R12");

        // R8 R9: loop counter paths
        drive(16'o077000 | (3'd3 << 6) | 6'd5, 4'h0, 16'h0800, 16'h0005, "R8");
        drive(16'o077000 | (3'd1 << 6) | 6'd63, 4'hA, 16'h0800, 16'h0002, "R9");
        drive(16'o077000 | (3'd7 << 6) | 6'd10, 4'h5, 16'h0800, 16'h0001, "R9");
        drive(16'o077000 | (3'd0 << 6) | 6'd1, 4'h3, 16'h0002, 16'h0000, "R9");
        drive(16'o077000 | (3'd5 << 6) | 6'd0, 4'hF, 16'h0900, 16'h0010, "R9");
        drive(16'o077000 | (3'd2 << 6) | 6'd8, 4'hC, 16'h0004, 16'h8000, "R8");

        // R10 R11: flag group
        for (int w = 16'o000240; w <= 16'o000277; w++) begin
            drive(16'(w), 4'b0101, 16'h0600, 16'h0, (w[3:0] == 0) ? "R11" : "R10");
            drive(16'(w), 4'b1010, 16'h0600, 16'h0, "R10");
        end

        // R13: unrelated words
        drive(16'o000000, 4'hF, 16'h0700, 16'h0, "R13");
        drive(16'o104000, 4'hF, 16'h0700, 16'h1, "R13");
        drive(16'o012700, 4'h0, 16'h0700, 16'h1, "R13");
        drive(16'o000237, 4'h5, 16'h0700, 16'h1, "R13");
        drive(16'o000300, 4'hA, 16'h0700, 16'h1, "R13");
        drive(16'o076777, 4'h3, 16'h0700, 16'h1, "R13");
        drive(16'o104400, 4'h0, 16'h0700, 16'h1, "R13");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule